// File: doc/BRIEF.md
# Range-Matched Fully Associative Translation Buffer

This block is a small fully associative address translation cache. Each slot holds an inclusive virtual address window (a first and a last address), a physical page number, a set of protection fields and a valid flag. Software-visible maintenance reaches the block through a single command port that accepts at most one command per clock. There are four commands:

- a page-mapping command that claims a slot for a page;
- a protection command that fills in that slot's protection fields and arms it;
- a single-page purge;
- a purge of the whole buffer.

A separate lookup port takes a virtual address and an instruction-fetch flag. One clock later it returns a registered result: a hit, or a miss classified as an instruction miss or a data miss. On a hit the result also carries the physical address and the stored protection fields. Checking those fields against a privilege level is left to the consumer.

Slot replacement prefers a slot whose window already covers the new page. Only when no slot covers it does the block take the slot under a round-robin pointer. A slot that is emptied gets an all-ones first address and a zero last address, so its window covers nothing.

Top module: `range_tlb`

## Requirements
- R1: After reset every slot is empty. Every lookup misses, rspValid is low until a lookup is issued, and protErr is low.
- R2: A lookup presented with lkValid high returns its result with rspValid high on the next clock. The result comes from the lowest-index slot whose first address is at most lkAddr and whose last address is at least lkAddr. rspHit is set when that slot is valid.
- R3: When no slot covers lkAddr, or the covering slot is not valid, the result is a miss. rspMissInstr is set if lkFetch was 1, and rspMissData otherwise. With rspValid high exactly one of rspHit, rspMissInstr and rspMissData is set; with rspValid low all three are low.
- R4: On a hit, rspPaddr equals the slot's 20-bit physical page number concatenated above lkAddr[PAGE_BITS-1:0]. On a miss, rspPaddr and rspProt are zero.
- R5: A page-mapping command (cmdOp = 0) sets the claimed slot as follows:
  - first address: cmdAddr with its low PAGE_BITS bits cleared;
  - last address: the first address plus 2^PAGE_BITS - 1;
  - physical page number: cmdData[24:5].
  The slot stays invalid, so lookups in that page miss until a protection command arrives.
- R6: A page-mapping command whose address is covered by existing slots empties every covering valid slot. It reuses the lowest-index covering slot and leaves the round-robin pointer unchanged.
- R7: A page-mapping command whose address no slot covers takes the slot at the round-robin pointer, discarding that slot's previous mapping. The pointer then advances, wrapping from ENTRIES-1 to 0; after reset it points at slot 0.
- R8: A protection command (cmdOp = 1) writes cmdData[29:1] into the lowest-index slot covering cmdAddr and makes that slot valid. On later hits rspProt[k] equals cmdData[k+1], where:
  - access id is cmdData[18:1];
  - U is bit 19;
  - PL2 is bits [21:20];
  - PL1 is bits [23:22];
  - type is bits [26:24];
  - B is bit 27, D is bit 28 and T is bit 29.
- R9: A protection command whose address no slot covers changes no slot. It raises protErr for exactly the one clock that follows it.
- R10: A page purge (cmdOp = 2) empties the lowest-index slot covering cmdAddr if that slot is valid, and leaves all other slots unchanged.
- R11: A purge-all (cmdOp = 3) empties every slot, so every lookup issued in the following cycles misses until slots are mapped and armed again.
- R12: A lookup issued in the same cycle as a command sees the slot contents from before that command.
- R13: While cmdValid is low, cmdOp, cmdAddr and cmdData have no effect on any slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 2 | 0 map page, 1 protection, 2 page purge, 3 purge all |
| cmdAddr | input | VA_W | Virtual address the command refers to |
| cmdData | input | 32 | Command data word (page number or protection fields) |
| lkValid | input | 1 | Lookup present this cycle |
| lkAddr | input | VA_W | Virtual address to translate |
| lkFetch | input | 1 | Lookup is an instruction fetch |
| rspValid | output | 1 | Lookup result present |
| rspHit | output | 1 | Translation found in a valid slot |
| rspMissInstr | output | 1 | Instruction-fetch miss |
| rspMissData | output | 1 | Data-access miss |
| rspPaddr | output | PA_W | Translated physical address |
| rspProt | output | 29 | Stored protection fields of the hit slot |
| protErr | output | 1 | Protection command found no covering slot |

## Verification
The assertions assume that cmdOp and lkFetch carry known values whenever cmdValid or lkValid is high. The purge-all property additionally assumes that no slot can turn valid within one cycle of that purge, which holds because arming a slot needs its own protection command. The stimulus drives all inputs only on the falling clock edge and keeps lkValid and cmdValid low during reset. It issues only whole-page mapping commands, so at most one slot covers any address. Every lookup is compared against a bench model of the slot table that applies the mapping, arming, purge and round-robin rules stated above.

// File: rtl/range_tlb_pkg.sv
package range_tlb_pkg;

  typedef enum logic [1:0] {
    OP_MAP_PAGE   = 2'd0,
    OP_SET_PROT   = 2'd1,
    OP_PURGE_PAGE = 2'd2,
    OP_PURGE_ALL  = 2'd3
  } tlbOp_e;

  localparam int PPN_W  = 20;
  localparam int PROT_W = 29;

  typedef struct packed {
    logic mapPage;
    logic setProt;
    logic flushAll;
  } tlbStrobe_t;

endpackage

// File: rtl/range_tlb_ctrl.sv
module range_tlb_ctrl
  import range_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdOp,
  input  logic [ENTRIES-1:0] cmdCover,
  input  logic [ENTRIES-1:0] entValid,
  output tlbStrobe_t         strobe,
  output logic [ENTRIES-1:0] tgtMask,
  output logic [ENTRIES-1:0] flushMask,
  output logic               protErr
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [IDX_W-1:0]   rrPtr;
  logic [ENTRIES-1:0] firstCov;
  logic [ENTRIES-1:0] rrOneHot;
  logic               anyCov;
  logic               rrAdvance;
  logic               errNext;

  // lowest set bit of the covering vector picks the first slot in index order
  assign firstCov = cmdCover & (~cmdCover + ENTRIES'(1));
  assign anyCov   = |cmdCover;
  assign rrOneHot = ENTRIES'(1) << rrPtr;

  always_comb begin
    strobe    = '0;
    tgtMask   = '0;
    flushMask = '0;
    rrAdvance = 1'b0;
    errNext   = 1'b0;
    if (cmdValid) begin
      case (tlbOp_e'(cmdOp))
        OP_MAP_PAGE: begin
          strobe.mapPage = 1'b1;
          flushMask      = cmdCover & entValid;
          tgtMask        = anyCov ? firstCov : rrOneHot;
          rrAdvance      = !anyCov;
        end
        OP_SET_PROT: begin
          strobe.setProt = anyCov;
          tgtMask        = firstCov;
          errNext        = !anyCov;
        end
        OP_PURGE_PAGE: flushMask = firstCov & entValid;
        OP_PURGE_ALL:  strobe.flushAll = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr   <= '0;
      protErr <= 1'b0;
    end else begin
      protErr <= errNext;
      if (rrAdvance)
        rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + IDX_W'(1);
    end
  end

endmodule

// File: rtl/range_tlb_dpath.sv
module range_tlb_dpath
  import range_tlb_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [VA_W-1:0]       cmdAddr,
  input  logic [31:0]           cmdData,
  input  tlbStrobe_t            strobe,
  input  logic [ENTRIES-1:0]    tgtMask,
  input  logic [ENTRIES-1:0]    flushMask,
  input  logic                  lkValid,
  input  logic [VA_W-1:0]       lkAddr,
  input  logic                  lkFetch,
  output logic [ENTRIES-1:0]    cmdCover,
  output logic [ENTRIES-1:0]    entValid,
  output logic                  rspValid,
  output logic                  rspHit,
  output logic                  rspMissInstr,
  output logic                  rspMissData,
  output logic [PPN_W+PAGE_BITS-1:0] rspPaddr,
  output logic [PROT_W-1:0]     rspProt
);

  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int PA_W  = PPN_W + PAGE_BITS;
  localparam logic [VA_W-1:0] PAGE_SPAN = VA_W'((64'd1 << PAGE_BITS) - 64'd1);

  logic [VA_W-1:0]   vaFirst [ENTRIES];
  logic [VA_W-1:0]   vaLast  [ENTRIES];
  logic [PPN_W-1:0]  ppn     [ENTRIES];
  logic [PROT_W-1:0] prot    [ENTRIES];

  logic [VA_W-1:0] mapFirst;
  logic            unusedData;
  logic [ENTRIES-1:0] lkCover;
  logic               lkFound;
  logic [IDX_W-1:0]   lkIdx;

  assign mapFirst   = cmdAddr & ~PAGE_SPAN;
  assign unusedData = ^{cmdData[31:30], cmdData[0]};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN || strobe.flushAll) begin
        vaFirst[g]  <= '1;
        vaLast[g]   <= '0;
        ppn[g]      <= '0;
        prot[g]     <= '0;
        entValid[g] <= 1'b0;
      end else if (strobe.mapPage && tgtMask[g]) begin
        vaFirst[g]  <= mapFirst;
        vaLast[g]   <= mapFirst + PAGE_SPAN;
        ppn[g]      <= cmdData[24:5];
        prot[g]     <= '0;
        entValid[g] <= 1'b0;
      end else if (strobe.setProt && tgtMask[g]) begin
        prot[g]     <= cmdData[29:1];
        entValid[g] <= 1'b1;
      end else if (flushMask[g]) begin
        vaFirst[g]  <= '1;
        vaLast[g]   <= '0;
        ppn[g]      <= '0;
        prot[g]     <= '0;
        entValid[g] <= 1'b0;
      end
    end

    assign cmdCover[g] = (vaFirst[g] <= cmdAddr) && (cmdAddr <= vaLast[g]);
    assign lkCover[g]  = (vaFirst[g] <= lkAddr)  && (lkAddr  <= vaLast[g]);
  end

  always_comb begin
    lkFound = 1'b0;
    lkIdx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkCover[i]) begin
        lkFound = 1'b1;
        lkIdx   = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid     <= 1'b0;
      rspHit       <= 1'b0;
      rspMissInstr <= 1'b0;
      rspMissData  <= 1'b0;
      rspPaddr     <= '0;
      rspProt      <= '0;
    end else begin
      rspValid     <= lkValid;
      rspHit       <= lkValid && lkFound && entValid[lkIdx];
      rspMissInstr <= lkValid && !(lkFound && entValid[lkIdx]) && lkFetch;
      rspMissData  <= lkValid && !(lkFound && entValid[lkIdx]) && !lkFetch;
      if (lkValid && lkFound && entValid[lkIdx]) begin
        rspPaddr <= PA_W'({ppn[lkIdx], lkAddr[PAGE_BITS-1:0]});
        rspProt  <= prot[lkIdx];
      end else begin
        rspPaddr <= '0;
        rspProt  <= '0;
      end
    end
  end

endmodule

// File: rtl/range_tlb.sv
module range_tlb
  import range_tlb_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  localparam int PA_W     = 20 + PAGE_BITS
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [1:0]      cmdOp,
  input  logic [VA_W-1:0] cmdAddr,
  input  logic [31:0]     cmdData,
  input  logic            lkValid,
  input  logic [VA_W-1:0] lkAddr,
  input  logic            lkFetch,
  output logic            rspValid,
  output logic            rspHit,
  output logic            rspMissInstr,
  output logic            rspMissData,
  output logic [PA_W-1:0] rspPaddr,
  output logic [28:0]     rspProt,
  output logic            protErr
);

  tlbStrobe_t         strobe;
  logic [ENTRIES-1:0] tgtMask;
  logic [ENTRIES-1:0] flushMask;
  logic [ENTRIES-1:0] cmdCover;
  logic [ENTRIES-1:0] entValid;

  range_tlb_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdCover(cmdCover), .entValid(entValid), .strobe(strobe),
    .tgtMask(tgtMask), .flushMask(flushMask), .protErr(protErr)
  );

  range_tlb_dpath #(.ENTRIES(ENTRIES), .VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .strobe(strobe), .tgtMask(tgtMask), .flushMask(flushMask),
    .lkValid(lkValid), .lkAddr(lkAddr), .lkFetch(lkFetch),
    .cmdCover(cmdCover), .entValid(entValid), .rspValid(rspValid),
    .rspHit(rspHit), .rspMissInstr(rspMissInstr), .rspMissData(rspMissData),
    .rspPaddr(rspPaddr), .rspProt(rspProt)
  );

endmodule

// File: rtl/range_tlb_chk.sv
module range_tlb_chk #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PA_W      = 32
) (
  input logic            clk,
  input logic            rstN,
  input logic            cmdValid,
  input logic [1:0]      cmdOp,
  input logic            lkValid,
  input logic [VA_W-1:0] lkAddr,
  input logic            lkFetch,
  input logic            rspValid,
  input logic            rspHit,
  input logic            rspMissInstr,
  input logic            rspMissData,
  input logic [PA_W-1:0] rspPaddr,
  input logic            protErr
);

  // R2: one-cycle registered response
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> rspValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !rspValid);

  // R3: exactly one outcome per response, none when idle
  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $countones({rspHit, rspMissInstr, rspMissData}) == 1);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(rspHit || rspMissInstr || rspMissData));
  a_r3_instr_kind: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && lkFetch |=> !rspMissData);
  a_r3_data_kind: assert property (@(posedge clk) disable iff (!rstN)
    lkValid && !lkFetch |=> !rspMissInstr);

  // R4: page offset passes straight through on a hit
  a_r4_offset: assert property (@(posedge clk) disable iff (!rstN)
    rspHit |-> rspPaddr[PAGE_BITS-1:0] == $past(lkAddr[PAGE_BITS-1:0]));

  // R9: error flag only after a protection command
  a_r9_err_source: assert property (@(posedge clk) disable iff (!rstN)
    protErr |-> $past(cmdValid && cmdOp == 2'd1));

  // R11: a lookup right after purge-all never hits
  a_r11_purge_all: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 2'd3) ##1 lkValid |=> !rspHit);

endmodule

bind range_tlb range_tlb_chk #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .lkValid(lkValid), .lkAddr(lkAddr), .lkFetch(lkFetch),
  .rspValid(rspValid), .rspHit(rspHit), .rspMissInstr(rspMissInstr),
  .rspMissData(rspMissData), .rspPaddr(rspPaddr), .protErr(protErr)
);

// File: tb/range_tlb_tb.sv
`timescale 1ns/1ps
module range_tlb_tb;

  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [1:0]  cmdOp = 2'd0;
  logic [31:0] cmdAddr = '0;
  logic [31:0] cmdData = '0;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        lkFetch = 1'b0;
  logic        rspValid, rspHit, rspMissInstr, rspMissData, protErr;
  logic [31:0] rspPaddr;
  logic [28:0] rspProt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the slot table
  logic [31:0] mFirst [N];
  logic [31:0] mLast  [N];
  logic [19:0] mPpn   [N];
  logic [28:0] mProt  [N];
  bit          mVal   [N];
  int          mRr;

  always #2.5 clk = ~clk;

  range_tlb u_dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .lkValid(lkValid),
    .lkAddr(lkAddr), .lkFetch(lkFetch), .rspValid(rspValid),
    .rspHit(rspHit), .rspMissInstr(rspMissInstr), .rspMissData(rspMissData),
    .rspPaddr(rspPaddr), .rspProt(rspProt), .protErr(protErr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void mEmpty(int i);
    mFirst[i] = '1; mLast[i] = '0; mPpn[i] = '0; mProt[i] = '0; mVal[i] = 0;
  endfunction

  function automatic int mFind(logic [31:0] a);
    for (int i = 0; i < N; i++)
      if (mFirst[i] <= a && a <= mLast[i]) return i;
    return -1;
  endfunction

  function automatic void mApply(logic [1:0] op, logic [31:0] a, logic [31:0] d);
    int f;
    case (op)
      2'd0: begin
        f = -1;
        for (int i = 0; i < N; i++)
          if (mFirst[i] <= a && a <= mLast[i]) begin
            if (mVal[i]) mEmpty(i);
            if (f < 0) f = i;
          end
        if (f < 0) begin f = mRr; mRr = (mRr + 1) % N; end
        mFirst[f] = {a[31:12], 12'h000};
        mLast[f]  = {a[31:12], 12'hfff};
        mPpn[f]   = d[24:5];
        mProt[f]  = '0;
        mVal[f]   = 0;
      end
      2'd1: begin
        f = mFind(a);
        if (f >= 0) begin mProt[f] = d[29:1]; mVal[f] = 1; end
      end
      2'd2: begin
        f = mFind(a);
        if (f >= 0 && mVal[f]) mEmpty(f);
      end
      default: for (int i = 0; i < N; i++) mEmpty(i);
    endcase
  endfunction

  function automatic logic [31:0] pageAddr(int k);
    return 32'h1000_0000 + 32'(k) * 32'h0000_3000;
  endfunction
  function automatic logic [31:0] mapData(int k);
    logic [19:0] p = 20'h80000 + 20'(k) * 20'h00123;
    return {7'd0, p, 5'd0};
  endfunction
  function automatic logic [31:0] protData(int k);
    logic [28:0] p = 29'h1F00_0001 ^ (29'(k) * 29'h0123_4567);
    return {2'b00, p, 1'b0};
  endfunction

  task automatic cmd(logic [1:0] op, logic [31:0] a, logic [31:0] d);
    bit expErr;
    expErr = (op == 2'd1) && (mFind(a) < 0);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdAddr = a; cmdData = d;
    @(negedge clk);
    cmdValid = 1'b0;
    mApply(op, a, d);
    chk("R9 protErr after command", 64'(protErr), 64'(expErr));
    if (expErr) begin
      @(negedge clk);
      chk("R9 protErr one cycle only", 64'(protErr), 64'd0);
    end
  endtask

  task automatic look(string tag, logic [31:0] a, logic f);
    int k;
    bit hit;
    k = mFind(a);
    hit = (k >= 0) && mVal[k];
    @(negedge clk);
    lkValid = 1'b1; lkAddr = a; lkFetch = f;
    @(negedge clk);
    lkValid = 1'b0;
    chk({tag, " R2 rspValid"}, 64'(rspValid), 64'd1);
    chk({tag, " R2 rspHit"}, 64'(rspHit), 64'(hit));
    chk({tag, " R3 miss kind"}, 64'({rspMissInstr, rspMissData}),
        hit ? 64'd0 : (f ? 64'd2 : 64'd1));
    chk({tag, " R4 paddr"}, 64'(rspPaddr), hit ? 64'({mPpn[k], a[11:0]}) : 64'd0);
    chk({tag, " R8 prot"}, 64'(rspProt), hit ? 64'(mProt[k]) : 64'd0);
  endtask

  task automatic sweep(string tag);
    for (int k = 0; k < 11; k++) begin
      look(tag, pageAddr(k), 1'b0);
      look(tag, pageAddr(k) + 32'hfff, 1'b1);
      look(tag, pageAddr(k) + 32'(k * 37), k[0]);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < N; i++) mEmpty(i);
    mRr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 rspValid after reset", 64'(rspValid), 64'd0);
    chk("R1 protErr after reset", 64'(protErr), 64'd0);
    look("R1 reset", 32'h0000_0000, 1'b0);
    look("R1 reset", 32'hffff_ffff, 1'b1);
    sweep("R1 empty");

    // R5 / R8: map then arm slots 0..7
    for (int k = 0; k < N; k++) begin
      cmd(2'd0, pageAddr(k) + 32'h0000_0abc, mapData(k));
      look("R5 unarmed", pageAddr(k) + 32'h10, 1'b0);
      cmd(2'd1, pageAddr(k) + 32'h0000_0123, protData(k));
      look("R8 armed", pageAddr(k) + 32'h20, 1'b1);
    end
    sweep("R2 full");

    // R7: ninth page evicts slot 0 (page 0)
    cmd(2'd0, pageAddr(8), mapData(8));
    cmd(2'd1, pageAddr(8), protData(8));
    sweep("R7 evict");

    // R6: remap a covered valid page, no pointer advance
    cmd(2'd0, pageAddr(3) + 32'h55, mapData(20));
    look("R6 remap empties", pageAddr(3), 1'b0);
    cmd(2'd1, pageAddr(3), protData(21));
    cmd(2'd0, pageAddr(9), mapData(9));
    cmd(2'd1, pageAddr(9), protData(9));
    sweep("R6 reuse R7 next victim");

    // R9: protection on unmapped page
    cmd(2'd1, pageAddr(10), protData(3));
    sweep("R9 unchanged");

    // R10: page purge of mapped and unmapped pages
    cmd(2'd2, pageAddr(5) + 32'h7ff, 32'h0);
    cmd(2'd2, pageAddr(10), 32'h0);
    sweep("R10 purge page");

    // R13: command fields without cmdValid
    @(negedge clk);
    cmdOp = 2'd3; cmdAddr = pageAddr(4); cmdData = 32'hffff_ffff;
    @(negedge clk);
    sweep("R13 idle command");

    // R12: same-cycle purge-all and lookup sees old contents
    begin
      int k;
      bit hit;
      k = mFind(pageAddr(4));
      hit = (k >= 0) && mVal[k];
      @(negedge clk);
      cmdValid = 1'b1; cmdOp = 2'd3;
      lkValid = 1'b1; lkAddr = pageAddr(4) + 32'h44; lkFetch = 1'b0;
      @(negedge clk);
      cmdValid = 1'b0; lkValid = 1'b0;
      chk("R12 same-cycle hit", 64'(rspHit), 64'(hit));
      chk("R12 same-cycle paddr", 64'(rspPaddr),
          hit ? 64'({mPpn[k], 12'h044}) : 64'd0);
      mApply(2'd3, 32'h0, 32'h0);
    end
    sweep("R11 after purge all");

    // R7 wrap: pointer continues after purge-all, map 9 pages again
    for (int k = 0; k < 9; k++) begin
      cmd(2'd0, pageAddr(k), mapData(k + 30));
      cmd(2'd1, pageAddr(k), protData(k + 30));
    end
    sweep("R7 wrap");

    finishRun();
  end

endmodule